// File: doc/BRIEF.md
# Exception Entry and Vector Controller

This block sits beside the control-register file of a 32-bit processor core and performs the state changes that happen when the core takes an exception. When `take_i` is pulsed with an exception code, the block does four things in one clock edge:

- it works out the resume address from the faulting PC, the branch-shadow (delay-slot) flag and the compact-ISA flag;
- it writes the resume address into the proper return register;
- it updates the status, cause and debug words;
- it presents the address of the handler the core must fetch next.

Three entry families are handled:

- **Ordinary traps and interrupts.** These vector through a boot-time base or a software-programmed base.
- **Cold reset, warm reset and non-maskable interrupt.** These set the error level and boot-exception flags.
- **Debug events.** These raise a per-cause flag and enter debug mode.

The core feeds the block its current status, cause and exception-base words and reads back the updated copies. Instruction fetch and pipeline flushing are left to the core.

Top module: `exc_vector_unit`

## Requirements
- R1: The resume address is the faulting PC with bit 0 replaced by `isa16_i`; when `in_delay_i` is 1, 2 is subtracted from it if `isa16_i` is 1, and 4 otherwise.
- R2: For an ordinary exception (codes 0 to 15), taken with status bit 1 (EXL) clear, `epc_o` takes the resume address, cause bit 31 (BD) takes `in_delay_i`, and status bit 1 is set in `status_o`.
- R3: For an ordinary exception taken with EXL set, `epc_o` keeps its previous value and cause bit 31 keeps its input value.
- R4: The ordinary handler base is 0xBFC00200 when status bit 22 (BEV) is 1; otherwise it is `ebase_i` with bits 9:0 cleared.
- R5: The handler offset added to the base is:
  - 0x000 for codes 2 or 3 with `refill_i` = 1 and EXL clear;
  - 0x200 for code 0 (interrupt) with cause bit 23 (IV) set;
  - 0x180 for every other case.
- R6: For an ordinary exception, cause bits 6:2 take the exception code. For code 11 only, cause bits 29:28 take `cop_num_i`.
- R7: Codes 16 (cold reset), 17 (warm reset) and 18 (NMI) each do the following:
  - write the resume address to `errorepc_o`;
  - set status bit 2 (ERL) and bit 22 (BEV);
  - present vector 0xBFC00000.

  Code 17 also sets status bit 20, and code 18 also sets status bit 19.
- R8: Debug codes write `depc_o` with the resume address, set `dbg_mode_o`, present vector 0xBFC00480 and leave `status_o` equal to `status_i`. Each code sets its own bit in `debug_o`:

  | Code | Debug event | `debug_o` bit |
  |------|-------------|---------------|
  | 19 | single step | 0 |
  | 22 | breakpoint | 1 |
  | 24 | data break load | 2 |
  | 23 | data break store | 3 |
  | 21 | instruction break | 4 |
  | 20 | debug interrupt | 5 |
- R9: For code 19 (single step), `depc_o` takes the PC with bit 0 replaced by `isa16_i`, with no delay-slot rewind.
- R10: Code 0 taken while `dbg_mode_i` is 1 is handled as a debug interrupt: it sets `debug_o` bit 5, uses the debug vector and leaves the cause word unchanged.
- R11: On every accepted entry, `ksu_o`, `isa16_o` and `dslot_o` become 0. On cycles with no entry, these three outputs and `dbg_mode_o` register `ksu_i`, `isa16_i`, `in_delay_i` and `dbg_mode_i`.
- R12: On reset-family or debug entry, cause bit 31 is cleared when EXL is clear and kept when EXL is set. No other cause bit changes.
- R13: The following timing and reset rules apply:
  - All results appear on the clock edge that samples `take_i`, and `done_o` is high for that one cycle.
  - Codes 25 to 31 are not accepted: `done_o` stays low and the held outputs do not change.
  - After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| take_i | input | 1 | Take the exception this cycle |
| exc_code_i | input | 5 | Exception code (0-15 ordinary, 16-24 reset/debug) |
| refill_i | input | 1 | TLB miss is a refill (codes 2/3) |
| cop_num_i | input | 2 | Coprocessor number for code 11 |
| fault_pc_i | input | 32 | PC of the faulting instruction |
| in_delay_i | input | 1 | Faulting instruction is in a delay slot |
| isa16_i | input | 1 | Core runs the 16-bit ISA |
| ksu_i | input | 2 | Current privilege mode |
| dbg_mode_i | input | 1 | Core is in debug mode |
| status_i | input | 32 | Current status word |
| cause_i | input | 32 | Current cause word |
| ebase_i | input | 32 | Exception base word |
| done_o | output | 1 | Entry performed last edge |
| vector_o | output | 32 | Handler address |
| epc_o | output | 32 | Return address for ordinary exceptions |
| errorepc_o | output | 32 | Return address for reset/NMI |
| depc_o | output | 32 | Return address for debug events |
| status_o | output | 32 | Updated status word |
| cause_o | output | 32 | Updated cause word |
| debug_o | output | 32 | Debug cause flags (accumulating) |
| ksu_o | output | 2 | Privilege mode after entry |
| isa16_o | output | 1 | ISA mode after entry |
| dslot_o | output | 1 | Delay-slot state after entry |
| dbg_mode_o | output | 1 | Debug mode after entry |

## Verification
Every result is registered once, so the outputs for an exception pulsed in one cycle are due after the very next rising edge, and `done_o` falls one edge later. The bench drives inputs and raises `take_i` on a falling edge, drops it on the following falling edge, and compares every output at that same falling edge, half a period after the capturing edge. A final check samples once more to confirm that `done_o` has fallen. The mode-tracking outputs are checked one full idle cycle after their inputs change. Checks that an output holds its value always compare against the value seen before the stimulus.

// File: rtl/exc_vector_unit.sv
module exc_vector_unit #(
  parameter logic [31:0] RESET_VEC = 32'hBFC0_0000,
  parameter logic [31:0] BOOT_BASE = 32'hBFC0_0200,
  parameter logic [31:0] DEBUG_VEC = 32'hBFC0_0480
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take_i,
  input  logic [4:0]  exc_code_i,
  input  logic        refill_i,
  input  logic [1:0]  cop_num_i,
  input  logic [31:0] fault_pc_i,
  input  logic        in_delay_i,
  input  logic        isa16_i,
  input  logic [1:0]  ksu_i,
  input  logic        dbg_mode_i,
  input  logic [31:0] status_i,
  input  logic [31:0] cause_i,
  input  logic [31:0] ebase_i,
  output logic        done_o,
  output logic [31:0] vector_o,
  output logic [31:0] epc_o,
  output logic [31:0] errorepc_o,
  output logic [31:0] depc_o,
  output logic [31:0] status_o,
  output logic [31:0] cause_o,
  output logic [31:0] debug_o,
  output logic [1:0]  ksu_o,
  output logic        isa16_o,
  output logic        dslot_o,
  output logic        dbg_mode_o
);
  localparam int ST_EXL = 1, ST_ERL = 2, ST_NMI = 19, ST_SR = 20, ST_BEV = 22;
  localparam int CA_BD = 31, CA_IV = 23;

  wire exl       = status_i[ST_EXL];
  wire int_dbg   = (exc_code_i == 5'd0) && dbg_mode_i;
  wire cls_gen   = !exc_code_i[4] && !int_dbg;
  wire cls_rst   = (exc_code_i >= 5'd16) && (exc_code_i <= 5'd18);
  wire cls_dbg   = ((exc_code_i >= 5'd19) && (exc_code_i <= 5'd24)) || int_dbg;
  wire accept    = take_i && (cls_gen || cls_rst || cls_dbg);

  wire [31:0] pc_isa = (fault_pc_i & ~32'd1) | {31'd0, isa16_i};
  wire [31:0] rewind = isa16_i ? 32'd2 : 32'd4;
  wire [31:0] resume = in_delay_i ? pc_isa - rewind : pc_isa;

  logic [31:0] gen_off, status_nx, cause_nx, vec_nx, dbg_bit;
  wire  [31:0] gen_base = status_i[ST_BEV] ? BOOT_BASE : (ebase_i & ~32'h3FF);

  always_comb begin
    if ((exc_code_i == 5'd2 || exc_code_i == 5'd3) && refill_i && !exl)
      gen_off = 32'h000;
    else if (exc_code_i == 5'd0 && cause_i[CA_IV])
      gen_off = 32'h200;
    else
      gen_off = 32'h180;
  end

  always_comb begin
    case (exc_code_i)
      5'd19:   dbg_bit = 32'h01;
      5'd22:   dbg_bit = 32'h02;
      5'd24:   dbg_bit = 32'h04;
      5'd23:   dbg_bit = 32'h08;
      5'd21:   dbg_bit = 32'h10;
      default: dbg_bit = 32'h20;
    endcase
  end

  always_comb begin
    status_nx = status_i;
    cause_nx  = cause_i;
    vec_nx    = DEBUG_VEC;
    if (cls_gen) begin
      status_nx[ST_EXL] = 1'b1;
      if (!exl) cause_nx[CA_BD] = in_delay_i;
      cause_nx[6:2] = exc_code_i;
      if (exc_code_i == 5'd11) cause_nx[29:28] = cop_num_i;
      vec_nx = gen_base + gen_off;
    end else if (cls_rst) begin
      status_nx[ST_ERL] = 1'b1;
      status_nx[ST_BEV] = 1'b1;
      if (exc_code_i == 5'd17) status_nx[ST_SR]  = 1'b1;
      if (exc_code_i == 5'd18) status_nx[ST_NMI] = 1'b1;
      if (!exl) cause_nx[CA_BD] = 1'b0;
      vec_nx = RESET_VEC;
    end else begin
      if (!exl) cause_nx[CA_BD] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o <= 1'b0;  vector_o <= '0;  epc_o <= '0;  errorepc_o <= '0;
      depc_o <= '0;    status_o <= '0;  cause_o <= '0; debug_o <= '0;
      ksu_o <= '0;     isa16_o <= 1'b0; dslot_o <= 1'b0; dbg_mode_o <= 1'b0;
    end else begin
      done_o <= accept;
      if (accept) begin
        vector_o <= vec_nx;
        status_o <= status_nx;
        cause_o  <= cause_nx;
        ksu_o    <= 2'b00;
        isa16_o  <= 1'b0;
        dslot_o  <= 1'b0;
        if (cls_gen && !exl) epc_o <= resume;
        if (cls_rst) errorepc_o <= resume;
        if (cls_dbg) begin
          depc_o     <= (exc_code_i == 5'd19) ? pc_isa : resume;
          debug_o    <= debug_o | dbg_bit;
          dbg_mode_o <= 1'b1;
        end else begin
          dbg_mode_o <= dbg_mode_i;
        end
      end else begin
        ksu_o      <= ksu_i;
        isa16_o    <= isa16_i;
        dslot_o    <= in_delay_i;
        dbg_mode_o <= dbg_mode_i;
      end
    end
  end

  assert_keep_epc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_i && !exc_code_i[4] && !dbg_mode_i && status_i[ST_EXL] |=> $stable(epc_o));
  assert_exl_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_i && !exc_code_i[4] && !dbg_mode_i |=> status_o[ST_EXL]);
  assert_reset_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_i && exc_code_i == 5'd16 |=> vector_o == RESET_VEC && status_o[ST_ERL] && status_o[ST_BEV]);
  assert_debug_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take_i && exc_code_i == 5'd21 |=> vector_o == DEBUG_VEC && dbg_mode_o && debug_o[4]);
  assert_int_in_debug_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take_i && exc_code_i == 5'd0 && dbg_mode_i |=> debug_o[5] && $stable(epc_o));
  assert_kernel_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ksu_o == 2'b00 && !isa16_o && !dslot_o);
  assert_reserved_R13: assert property (@(posedge clk) disable iff (!rst_n)
    take_i && exc_code_i > 5'd24 |=> !done_o && $stable(vector_o));
endmodule

// File: tb/test_exc_vector_unit.sv
module test_exc_vector_unit;
  logic clk = 0, rst_n = 0, take = 0;
  logic [4:0] code = 0;
  logic refill = 0, dly = 0, isa = 0, dbgm = 0;
  logic [1:0] cop = 0, ksu = 0;
  logic [31:0] pc = 0, st = 0, ca = 0, eb = 0;
  logic done;
  logic [31:0] vec, epc, eepc, depc, st_o, ca_o, dbg_o;
  logic [1:0] ksu_o;
  logic isa_o, dsl_o, dbgm_o;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  exc_vector_unit i_exc_vector_unit (
    .clk(clk), .rst_n(rst_n), .take_i(take), .exc_code_i(code), .refill_i(refill),
    .cop_num_i(cop), .fault_pc_i(pc), .in_delay_i(dly), .isa16_i(isa), .ksu_i(ksu),
    .dbg_mode_i(dbgm), .status_i(st), .cause_i(ca), .ebase_i(eb), .done_o(done),
    .vector_o(vec), .epc_o(epc), .errorepc_o(eepc), .depc_o(depc), .status_o(st_o),
    .cause_o(ca_o), .debug_o(dbg_o), .ksu_o(ksu_o), .isa16_o(isa_o), .dslot_o(dsl_o),
    .dbg_mode_o(dbgm_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fire();
    @(negedge clk) take = 1;
    @(negedge clk) take = 0;
  endtask

  // ctrl: [4:0] code, [5] refill, [6] dly, [7] isa, [8] bev, [9] exl, [10] iv, [12:11] cop
  // row: ctrl, pc, ebase, expected vector, expected epc
  localparam int NROW = 10;
  localparam logic [31:0] TBL [NROW][5] = '{
    '{32'h0008, 32'h8000_0100, 32'h8000_1234, 32'h8000_1180, 32'h8000_0100},
    '{32'h0048, 32'h8000_0204, 32'h8000_1234, 32'h8000_1180, 32'h8000_0200},
    '{32'h01CA, 32'h8000_0302, 32'h8000_1234, 32'hBFC0_0380, 32'h8000_0301},
    '{32'h0022, 32'h0040_0000, 32'h8000_1234, 32'h8000_1000, 32'h0040_0000},
    '{32'h0223, 32'h0050_0000, 32'h8000_1234, 32'h8000_1180, 32'h0040_0000},
    '{32'h0480, 32'h8000_0010, 32'h9000_03FF, 32'h9000_0200, 32'h8000_0011},
    '{32'h0100, 32'h8000_0020, 32'h8000_1234, 32'hBFC0_0380, 32'h8000_0020},
    '{32'h100B, 32'h8000_0030, 32'h8000_1234, 32'h8000_1180, 32'h8000_0030},
    '{32'h0002, 32'h0000_0040, 32'h8000_1234, 32'h8000_1180, 32'h0000_0040},
    '{32'h0740, 32'h0000_1000, 32'h8000_1234, 32'hBFC0_0400, 32'h0000_0040}
  };

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] exp_ca, hold;
    repeat (3) @(negedge clk);
    chk("R13 reset vector", vec, 0);
    chk("R13 reset epc", epc, 0);
    chk("R13 reset done", {31'd0, done}, 0);
    rst_n = 1;

    for (int i = 0; i < NROW; i++) begin
      logic [31:0] c;
      c = TBL[i][0];
      @(negedge clk);
      code = c[4:0]; refill = c[5]; dly = c[6]; isa = c[7];
      cop = c[12:11]; pc = TBL[i][1]; eb = TBL[i][2];
      st = 32'h10 | (c[8] << 22) | (c[9] << 1);
      ca = 32'h8000_007C | (c[10] << 23);
      exp_ca = ca;
      if (!c[9]) exp_ca[31] = c[6];
      exp_ca[6:2] = c[4:0];
      if (c[4:0] == 5'd11) exp_ca[29:28] = c[12:11];
      fire();
      chk("R4 R5 vector", vec, TBL[i][3]);
      chk("R1 R2 R3 epc", epc, TBL[i][4]);
      chk("R6 R2 R3 cause", ca_o, exp_ca);
      chk("R2 status", st_o, st | 32'h2);
      chk("R13 done", {31'd0, done}, 1);
    end

    // R7 cold reset, EXL clear
    @(negedge clk);
    code = 16; pc = 32'hBFC0_1000; dly = 0; isa = 0; st = 32'h10; ca = 32'h8000_0000;
    fire();
    chk("R7 reset errorepc", eepc, 32'hBFC0_1000);
    chk("R7 reset status", st_o, 32'h0040_0014);
    chk("R7 reset vector", vec, 32'hBFC0_0000);
    chk("R12 reset BD cleared", ca_o, 32'h0);
    // R7 warm reset sets bit 20
    @(negedge clk); code = 17;
    fire();
    chk("R7 soft reset status", st_o, 32'h0050_0014);
    // R7 NMI with EXL set keeps BD, rewind R1
    @(negedge clk);
    code = 18; pc = 32'h8000_0106; dly = 1; isa = 1; st = 32'h12;
    fire();
    chk("R7 R1 nmi errorepc", eepc, 32'h8000_0105);
    chk("R7 nmi status", st_o, 32'h0048_0016);
    chk("R12 nmi BD kept", ca_o, 32'h8000_0000);

    // R8 instruction break with rewind
    @(negedge clk);
    code = 21; pc = 32'h8000_0208; dly = 1; isa = 0; st = 32'h10; ca = 32'h8000_007C;
    hold = epc;
    fire();
    chk("R8 depc", depc, 32'h8000_0204);
    chk("R8 vector", vec, 32'hBFC0_0480);
    chk("R8 debug bit4", dbg_o & 32'h10, 32'h10);
    chk("R8 dbg mode", {31'd0, dbgm_o}, 1);
    chk("R8 status", st_o, 32'h10);
    chk("R12 debug BD cleared", ca_o, 32'h0000_007C);
    chk("R8 epc untouched", epc, hold);
    // R9 single step, no rewind
    @(negedge clk);
    code = 19; pc = 32'h8000_0300; dly = 1; isa = 1;
    fire();
    chk("R9 dss depc", depc, 32'h8000_0301);
    chk("R9 dss bit0", dbg_o & 32'h1, 32'h1);
    // R10 interrupt in debug mode
    @(negedge clk);
    code = 0; dbgm = 1; st = 32'h12; ca = 32'h0000_007C; dly = 0;
    fire();
    chk("R10 dint bit5", dbg_o & 32'h20, 32'h20);
    chk("R10 vector", vec, 32'hBFC0_0480);
    chk("R10 cause unchanged", ca_o, 32'h0000_007C);
    chk("R10 epc unchanged", epc, hold);

    // R11 mode tracking then forced on entry
    @(negedge clk);
    dbgm = 0; ksu = 2; isa = 1; dly = 1;
    @(negedge clk);
    chk("R11 track", {26'd0, ksu_o, isa_o, dsl_o, dbgm_o, 1'b0}, {26'd0, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0});
    code = 8; st = 32'h10;
    fire();
    chk("R11 forced", {28'd0, ksu_o, isa_o, dsl_o}, 0);
    @(negedge clk);
    chk("R13 done one cycle", {31'd0, done}, 0);

    // R13 reserved code ignored
    hold = vec;
    @(negedge clk); code = 28;
    fire();
    chk("R13 reserved no done", {31'd0, done}, 0);
    chk("R13 reserved vector held", vec, hold);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule